// File: doc/BRIEF.md
# Storage Host Descriptor Chain Walker

This block runs a linked run of command/data descriptors for an SD/eMMC-style host controller. Software writes the address of the first descriptor, with bit 0 set as a run flag, to a start register. The walker then reads each 16-byte descriptor from memory through a single-outstanding read port. Depending on the descriptor's flags, it runs a command phase, a data phase, or both, through request/done handshakes to an abstract card-side engine. After each command phase it writes the card's response word back into the descriptor. The walker stops at the descriptor flagged as the last one and raises a status bit.

A descriptor occupies four consecutive 32-bit words: configuration at offset 0, command argument at offset 4, buffer address at offset 8 and response at offset 12. The walker reads the first three words and writes only the fourth. A later descriptor may skip its command phase. This lets one card command stream into several scattered buffers, each with its own length unit.

Configuration word fields:
- bits 8:0: length.
- bit 9: block unit.
- bit 10: response with busy.
- bit 11: data phase present.
- bit 12: write direction.
- bits 19:16: log2 timeout in ms.
- bit 20: skip command.
- bit 21: last descriptor.
- bits 29:24: command index.

Top module: `sdcw_chain_walker`

## Requirements
- R1: After reset the start register reads 0, no memory read, command or data request is raised, and both status bits are 0.
- R2: A start-register write with bit 0 = 1 clears both status bits and starts the walk at the written address with its low 4 bits cleared. While the walk runs, the register reads back the written value with bit 0 = 1. Bit 0 reads 0 once the walk ends.
- R3: Descriptor i is fetched as three single-word reads, in order, at base+16*i+0, +4 and +8.
- R4: Unless bit 20 is set, a descriptor raises `cmd_req` carrying the full configuration word and the argument word. The request is held until `cmd_done`. With bit 20 set, no command request is raised for that descriptor.
- R5: On `cmd_done`, the walker writes `cmd_resp` to base+16*i+12 with a single write strobe.
- R6: When bit 11 is set, `dat_req` carries:
  - the buffer address;
  - the write flag from bit 12;
  - the timeout from bits 19:16;
  - the byte count: bits 8:0 when bit 9 is 0, or bits 8:0 times 2^BLK_LOG2 (512 by default) when bit 9 is 1.

  The request is held until `dat_done`, and the data phase follows the command phase.
- R7: After the descriptor with bit 21 set, the walk ends and `irq_eoc` is set. It stays set until the next start.
- R8: A descriptor with bit 11 set and a buffer address whose bits 2:0 are not zero ends the walk with `irq_err` set, before any command or data request for that descriptor. When bit 11 is clear, the buffer address is ignored.
- R9: If MAX_DESC (256) descriptors run without bit 21, the walk ends with `irq_err` set and descriptor MAX_DESC is never fetched.
- R10: A start-register write with bit 0 = 0 stops the walk on the next edge: requests drop, the start register reads 0, and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Start register write strobe |
| start_wdata | input | 32 | Start register write value (address, bit 0 run flag) |
| start_rdata | output | 32 | Start register readback |
| mem_rd_req | output | 1 | One-cycle descriptor word read request |
| mem_rd_addr | output | 32 | Byte address of the read |
| mem_rd_valid | input | 1 | Read data valid (one cycle) |
| mem_rd_data | input | 32 | Read data |
| mem_wr_en | output | 1 | Response write strobe |
| mem_wr_addr | output | 32 | Response write address |
| mem_wr_data | output | 32 | Response write data |
| cmd_req | output | 1 | Command phase request, held until done |
| cmd_cfg | output | 32 | Configuration word of the current descriptor |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Command phase complete |
| cmd_resp | input | 32 | Response word, valid with cmd_done |
| dat_req | output | 1 | Data phase request, held until done |
| dat_write | output | 1 | Data direction, 1 = write to card |
| dat_addr | output | 32 | Buffer address |
| dat_bytes | output | 18 | Transfer size in bytes |
| dat_timeout | output | 4 | log2 of timeout in ms |
| dat_done | input | 1 | Data phase complete |
| irq_eoc | output | 1 | Chain finished status |
| irq_err | output | 1 | Chain aborted on error status |

## Verification
A walker holding a wrong descriptor address or index shows up at the next fetch: the read address leaves the expected +16 stride, or a read past the last legal entry appears. A wrong latched configuration word shows up as soon as the next phase issues. It appears as a command request that should have been skipped, a byte count in the wrong unit, or a response written to the wrong slot. Status and stop errors appear within one cycle of the end of a walk or of the stop write, through the readback bit and the status outputs.

// File: rtl/sdcw_pkg.sv
package sdcw_pkg;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 9;
  localparam int TMO_W      = 4;
  localparam int FETCH_WDS  = 3;   // words read per descriptor
  localparam int DESC_BYTES = 16;
  localparam int RESP_OFS   = 12;

  // configuration word bit positions
  localparam int B_BLK   = 9;
  localparam int B_DAT   = 11;
  localparam int B_WR    = 12;
  localparam int B_TMO   = 16;
  localparam int B_NOCMD = 20;
  localparam int B_EOC   = 21;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             blk;
    logic             dat;
    logic             wr;
    logic [TMO_W-1:0] tmo;
    logic             nocmd;
    logic             eoc;
  } cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_CMD, S_WB, S_DATA, S_NEXT
  } walk_st_t;
endpackage

// File: rtl/sdcw_len_scale.sv
module sdcw_len_scale #(
  parameter int LEN_W    = 9,
  parameter int BLK_LOG2 = 9
) (
  input  logic [LEN_W-1:0]          len,
  input  logic                      blk,
  output logic [LEN_W+BLK_LOG2-1:0] bytes
);
  localparam int OUT_W = LEN_W + BLK_LOG2;

  generate
    if (BLK_LOG2 == 0) begin : g_unit
      assign bytes = len;
    end else begin : g_shift
      logic [OUT_W-1:0] as_bytes, as_blocks;
      assign as_bytes  = {{BLK_LOG2{1'b0}}, len};
      assign as_blocks = {len, {BLK_LOG2{1'b0}}};
      assign bytes     = blk ? as_blocks : as_bytes;
    end
  endgenerate
endmodule

// File: rtl/sdcw_desc_fetch.sv
module sdcw_desc_fetch #(
  parameter int NWORDS = 3,
  parameter int WORD_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          abort,
  input  logic                          go,
  input  logic [WORD_W-1:0]             base,
  output logic                          rd_req,
  output logic [WORD_W-1:0]             rd_addr,
  input  logic                          rd_valid,
  input  logic [WORD_W-1:0]             rd_data,
  output logic [NWORDS-1:0][WORD_W-1:0] words,
  output logic                          done
);
  localparam int CW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [CW-1:0]     LAST_W = CW'(NWORDS - 1);
  localparam logic [WORD_W-1:0] STEP   = WORD_W'(WORD_W / 8);

  logic          active;
  logic [CW-1:0] widx;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active  <= 1'b0;
      widx    <= '0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      done    <= 1'b0;
      words   <= '0;
    end else begin
      rd_req <= 1'b0;
      done   <= 1'b0;
      if (go) begin
        active  <= 1'b1;
        widx    <= '0;
        rd_req  <= 1'b1;
        rd_addr <= base;
      end else if (active && rd_valid) begin
        words[widx] <= rd_data;
        if (widx == LAST_W) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          widx    <= widx + 1'b1;
          rd_req  <= 1'b1;
          rd_addr <= rd_addr + STEP;
        end
      end
    end
  end
endmodule

// File: rtl/sdcw_chain_walker.sv
module sdcw_chain_walker
  import sdcw_pkg::*;
#(
  parameter int MAX_DESC = 256,
  parameter int BLK_LOG2 = 9,
  parameter int BYTES_W  = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_wr,
  input  logic [31:0]        start_wdata,
  output logic [31:0]        start_rdata,
  output logic               mem_rd_req,
  output logic [31:0]        mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [31:0]        mem_rd_data,
  output logic               mem_wr_en,
  output logic [31:0]        mem_wr_addr,
  output logic [31:0]        mem_wr_data,
  output logic               cmd_req,
  output logic [31:0]        cmd_cfg,
  output logic [31:0]        cmd_arg,
  input  logic               cmd_done,
  input  logic [31:0]        cmd_resp,
  output logic               dat_req,
  output logic               dat_write,
  output logic [31:0]        dat_addr,
  output logic [BYTES_W-1:0] dat_bytes,
  output logic [3:0]         dat_timeout,
  input  logic               dat_done,
  output logic               irq_eoc,
  output logic               irq_err
);
  localparam int IDX_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(MAX_DESC - 1);
  localparam logic [WORD_W-1:0] D_STEP   = WORD_W'(DESC_BYTES);
  localparam logic [WORD_W-1:0] R_OFS    = WORD_W'(RESP_OFS);

  walk_st_t                         st;
  logic                             busy_q;
  logic [31:1]                      base_q;
  logic [WORD_W-1:0]                desc_addr;
  logic [IDX_W-1:0]                 dcnt;
  logic [WORD_W-1:0]                cfg_q, arg_q, buf_q;
  cfg_t                             cfg;
  logic                             fetch_go, fetch_done;
  logic [FETCH_WDS-1:0][WORD_W-1:0] fwords;
  logic [BYTES_W-1:0]               bytes_c;
  logic                             misaligned;

  sdcw_desc_fetch #(.NWORDS(FETCH_WDS), .WORD_W(WORD_W)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .abort    (start_wr),
    .go       (fetch_go),
    .base     (desc_addr),
    .rd_req   (mem_rd_req),
    .rd_addr  (mem_rd_addr),
    .rd_valid (mem_rd_valid),
    .rd_data  (mem_rd_data),
    .words    (fwords),
    .done     (fetch_done)
  );

  always_comb begin
    cfg.len   = cfg_q[LEN_W-1:0];
    cfg.blk   = cfg_q[B_BLK];
    cfg.dat   = cfg_q[B_DAT];
    cfg.wr    = cfg_q[B_WR];
    cfg.tmo   = cfg_q[B_TMO +: TMO_W];
    cfg.nocmd = cfg_q[B_NOCMD];
    cfg.eoc   = cfg_q[B_EOC];
  end

  sdcw_len_scale #(.LEN_W(LEN_W), .BLK_LOG2(BLK_LOG2)) u_scale (
    .len   (cfg.len),
    .blk   (cfg.blk),
    .bytes (bytes_c)
  );

  assign misaligned = cfg.dat && (buf_q[2:0] != 3'b000);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      busy_q      <= 1'b0;
      base_q      <= '0;
      desc_addr   <= '0;
      dcnt        <= '0;
      cfg_q       <= '0;
      arg_q       <= '0;
      buf_q       <= '0;
      fetch_go    <= 1'b0;
      cmd_req     <= 1'b0;
      dat_req     <= 1'b0;
      dat_bytes   <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      irq_eoc     <= 1'b0;
      irq_err     <= 1'b0;
    end else begin
      fetch_go  <= 1'b0;
      mem_wr_en <= 1'b0;
      if (start_wr) begin
        cmd_req <= 1'b0;
        dat_req <= 1'b0;
        base_q  <= start_wdata[31:1];
        if (start_wdata[0]) begin
          busy_q    <= 1'b1;
          desc_addr <= {start_wdata[31:4], 4'b0000};
          dcnt      <= '0;
          irq_eoc   <= 1'b0;
          irq_err   <= 1'b0;
          fetch_go  <= 1'b1;
          st        <= S_FETCH;
        end else begin
          busy_q <= 1'b0;
          st     <= S_IDLE;
        end
      end else begin
        case (st)
          S_IDLE: ;
          S_FETCH: begin
            if (fetch_done) begin
              cfg_q <= fwords[0];
              arg_q <= fwords[1];
              buf_q <= fwords[2];
              st    <= S_CHECK;
            end
          end
          S_CHECK: begin
            if (misaligned) begin
              irq_err <= 1'b1;
              busy_q  <= 1'b0;
              st      <= S_IDLE;
            end else if (!cfg.nocmd) begin
              cmd_req <= 1'b1;
              st      <= S_CMD;
            end else if (cfg.dat) begin
              dat_req   <= 1'b1;
              dat_bytes <= bytes_c;
              st        <= S_DATA;
            end else begin
              st <= S_NEXT;
            end
          end
          S_CMD: begin
            if (cmd_done) begin
              cmd_req     <= 1'b0;
              mem_wr_en   <= 1'b1;
              mem_wr_addr <= desc_addr + R_OFS;
              mem_wr_data <= cmd_resp;
              st          <= S_WB;
            end
          end
          S_WB: begin
            if (cfg.dat) begin
              dat_req   <= 1'b1;
              dat_bytes <= bytes_c;
              st        <= S_DATA;
            end else begin
              st <= S_NEXT;
            end
          end
          S_DATA: begin
            if (dat_done) begin
              dat_req <= 1'b0;
              st      <= S_NEXT;
            end
          end
          S_NEXT: begin
            if (cfg.eoc) begin
              irq_eoc <= 1'b1;
              busy_q  <= 1'b0;
              st      <= S_IDLE;
            end else if (dcnt == LAST_IDX) begin
              irq_err <= 1'b1;
              busy_q  <= 1'b0;
              st      <= S_IDLE;
            end else begin
              dcnt      <= dcnt + 1'b1;
              desc_addr <= desc_addr + D_STEP;
              fetch_go  <= 1'b1;
              st        <= S_FETCH;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign start_rdata = {base_q, busy_q};
  assign cmd_cfg     = cfg_q;
  assign cmd_arg     = arg_q;
  assign dat_addr    = buf_q;
  assign dat_write   = cfg.wr;
  assign dat_timeout = cfg.tmo;
endmodule

// File: rtl/sdcw_chain_walker_sva.sv
module sdcw_chain_walker_sva (
  input logic        clk,
  input logic        rst,
  input logic        start_wr,
  input logic [31:0] start_wdata,
  input logic [31:0] start_rdata,
  input logic        mem_rd_req,
  input logic        cmd_req,
  input logic        cmd_done,
  input logic        dat_req,
  input logic        dat_done,
  input logic [31:0] dat_addr,
  input logic        irq_eoc,
  input logic        irq_err
);
  // R4: command and data phases never overlap
  p_phase_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(cmd_req && dat_req));

  // R4: a pending command request is held until done or a register write
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && !cmd_done && !start_wr) |=> cmd_req);

  // R6: a pending data request is held until done or a register write
  p_dat_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (dat_req && !dat_done && !start_wr) |=> dat_req);

  // R8: no data request ever carries a misaligned buffer
  p_dat_align_r8: assert property (@(posedge clk) disable iff (rst)
    dat_req |-> (dat_addr[2:0] == 3'b000));

  // R7: end status appears together with the readback run flag dropping
  p_eoc_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_eoc) |-> !start_rdata[0]);

  // R7: end and error status are never both set
  p_status_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(irq_eoc && irq_err));

  // R2: nothing is requested while the run flag reads 0
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !start_rdata[0] |-> !(mem_rd_req || cmd_req || dat_req));

  // R10: a stop write clears the run flag and the phase requests
  p_stop_r10: assert property (@(posedge clk) disable iff (rst)
    (start_wr && !start_wdata[0]) |=> (!start_rdata[0] && !cmd_req && !dat_req));
endmodule

bind sdcw_chain_walker sdcw_chain_walker_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .start_wr    (start_wr),
  .start_wdata (start_wdata),
  .start_rdata (start_rdata),
  .mem_rd_req  (mem_rd_req),
  .cmd_req     (cmd_req),
  .cmd_done    (cmd_done),
  .dat_req     (dat_req),
  .dat_done    (dat_done),
  .dat_addr    (dat_addr),
  .irq_eoc     (irq_eoc),
  .irq_err     (irq_err)
);

// File: tb/sdcw_chain_walker_tb_top.sv
`timescale 1ns/1ps
module sdcw_chain_walker_tb_top;
  localparam int MAX_DESC  = 256;
  localparam int BLK_LOG2  = 9;
  localparam int BYTES_W   = 18;
  localparam int MEM_WORDS = 2048;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst = 1'b1;
  logic               start_wr = 1'b0;
  logic [31:0]        start_wdata = '0;
  logic [31:0]        start_rdata;
  logic               mem_rd_req;
  logic [31:0]        mem_rd_addr;
  logic               mem_rd_valid = 1'b0;
  logic [31:0]        mem_rd_data = '0;
  logic               mem_wr_en;
  logic [31:0]        mem_wr_addr, mem_wr_data;
  logic               cmd_req;
  logic [31:0]        cmd_cfg, cmd_arg;
  logic               cmd_done = 1'b0;
  logic [31:0]        cmd_resp = '0;
  logic               dat_req, dat_write;
  logic [31:0]        dat_addr;
  logic [BYTES_W-1:0] dat_bytes;
  logic [3:0]         dat_timeout;
  logic               dat_done = 1'b0;
  logic               irq_eoc, irq_err;

  sdcw_chain_walker #(.MAX_DESC(MAX_DESC), .BLK_LOG2(BLK_LOG2), .BYTES_W(BYTES_W)) dut_i (
    .clk(clk), .rst(rst), .start_wr(start_wr), .start_wdata(start_wdata),
    .start_rdata(start_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .cmd_req(cmd_req),
    .cmd_cfg(cmd_cfg), .cmd_arg(cmd_arg), .cmd_done(cmd_done), .cmd_resp(cmd_resp),
    .dat_req(dat_req), .dat_write(dat_write), .dat_addr(dat_addr),
    .dat_bytes(dat_bytes), .dat_timeout(dat_timeout), .dat_done(dat_done),
    .irq_eoc(irq_eoc), .irq_err(irq_err)
  );

  logic [31:0] mem [MEM_WORDS];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  logic [63:0] q_cmd [$];
  logic [31:0] q_wb  [$];
  logic [31:0] q_rd  [$];
  logic [54:0] q_dat [$];
  logic        exp_eoc, exp_err;
  logic [31:0] exp_rd = '0;
  logic [31:0] last_resp = '0;
  logic [31:0] resp_seq = 32'hC0DE_0000;
  logic [63:0] e64;
  logic [54:0] e55;
  logic [31:0] e32;
  logic        p_cmd = 1'b0, p_dat = 1'b0;
  int          ccnt = 0, dcnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int idx, input int len, input bit blk,
      input bit bsy, input bit dat, input bit wr, input int tmo, input bit nocmd, input bit eoc);
    logic [31:0] c;
    c = '0;
    c[8:0] = len[8:0]; c[9] = blk; c[10] = bsy; c[11] = dat; c[12] = wr;
    c[19:16] = tmo[3:0]; c[20] = nocmd; c[21] = eoc; c[29:24] = idx[5:0];
    return c;
  endfunction

  task automatic put(input int base, input int i, input logic [31:0] c,
                     input logic [31:0] a, input logic [31:0] b);
    int w;
    w = (base + 16 * i) >> 2;
    mem[w] = c; mem[w+1] = a; mem[w+2] = b; mem[w+3] = 32'hFFFF_FFFF;
  endtask

  // behavioural walk of the chain following the requirements
  task automatic predict(input int base);
    int a;
    logic [31:0] c, g, b;
    logic [BYTES_W-1:0] nb;
    exp_eoc = 1'b0; exp_err = 1'b0;
    for (int n = 0; n < MAX_DESC; n++) begin
      a = base + 16 * n;
      c = mem[a >> 2]; g = mem[(a >> 2) + 1]; b = mem[(a >> 2) + 2];
      q_rd.push_back(a); q_rd.push_back(a + 4); q_rd.push_back(a + 8);
      if (c[11] && b[2:0] != 3'b000) begin exp_err = 1'b1; return; end
      if (!c[20]) begin q_cmd.push_back({c, g}); q_wb.push_back(a + 12); end
      if (c[11]) begin
        nb = c[9] ? (BYTES_W'(c[8:0]) << BLK_LOG2) : BYTES_W'(c[8:0]);
        q_dat.push_back({c[12], c[19:16], b, nb});
      end
      if (c[21]) begin exp_eoc = 1'b1; return; end
    end
    exp_err = 1'b1;
  endtask

  task automatic clear_q();
    q_cmd.delete(); q_wb.delete(); q_rd.delete(); q_dat.delete();
  endtask

  task automatic sw_write(input logic [31:0] v);
    @(negedge clk);
    start_wdata = v; start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
  endtask

  task automatic run_chain(input int base, input string errtag);
    clear_q();
    predict(base);
    exp_rd = 32'(base) | 32'h1;
    sw_write(32'(base) | 32'h1);
    check(start_rdata == exp_rd, "R2", "run flag after start", start_rdata, exp_rd);
    while (start_rdata[0]) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q_rd.size() == 0, "R3", "descriptor reads left", q_rd.size(), 0);
    check(q_cmd.size() == 0, "R4", "commands left", q_cmd.size(), 0);
    check(q_wb.size() == 0, "R5", "response writes left", q_wb.size(), 0);
    check(q_dat.size() == 0, "R6", "data phases left", q_dat.size(), 0);
    check(irq_eoc == exp_eoc, "R7", "end status", irq_eoc, exp_eoc);
    check(irq_err == exp_err, errtag, "error status", irq_err, exp_err);
    check(start_rdata == 32'(base), "R2", "readback after end", start_rdata, base);
  endtask

  // memory model: one-cycle read latency
  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (mem_rd_req) begin
      mem_rd_valid = 1'b1;
      mem_rd_data  = mem[mem_rd_addr[12:2]];
    end
    if (mem_wr_en) mem[mem_wr_addr[12:2]] = mem_wr_data;
  end

  // card command engine model
  always @(negedge clk) begin
    if (cmd_done) cmd_done = 1'b0;
    else if (cmd_req) begin
      if (ccnt == 2) begin
        resp_seq  = resp_seq + 1;
        cmd_resp  = resp_seq;
        last_resp = resp_seq;
        cmd_done  = 1'b1;
        ccnt      = 0;
      end else ccnt++;
    end else ccnt = 0;
  end

  // card data engine model
  always @(negedge clk) begin
    if (dat_done) dat_done = 1'b0;
    else if (dat_req) begin
      if (dcnt == 3) begin dat_done = 1'b1; dcnt = 0; end
      else dcnt++;
    end else dcnt = 0;
  end

  // per-clock comparison against the reference queues
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_req) begin
        if (q_rd.size() == 0) check(1'b0, "R9", "read beyond chain", mem_rd_addr, 0);
        else begin
          e32 = q_rd.pop_front();
          check(mem_rd_addr == e32, "R3", "fetch address", mem_rd_addr, e32);
        end
      end
      if (cmd_req && !p_cmd) begin
        if (q_cmd.size() == 0) check(1'b0, "R4", "unexpected command", cmd_cfg, 0);
        else begin
          e64 = q_cmd.pop_front();
          check({cmd_cfg, cmd_arg} == e64, "R4", "command fields", {cmd_cfg, cmd_arg}, e64);
        end
      end
      if (dat_req && !p_dat) begin
        if (q_dat.size() == 0) check(1'b0, "R6", "unexpected data phase", dat_addr, 0);
        else begin
          e55 = q_dat.pop_front();
          check({dat_write, dat_timeout, dat_addr, dat_bytes} == e55, "R6", "data fields",
                64'({dat_write, dat_timeout, dat_addr, dat_bytes}), 64'(e55));
        end
      end
      if (mem_wr_en) begin
        if (q_wb.size() == 0) check(1'b0, "R5", "unexpected write", mem_wr_addr, 0);
        else begin
          e32 = q_wb.pop_front();
          check(mem_wr_addr == e32, "R5", "response address", mem_wr_addr, e32);
          check(mem_wr_data == last_resp, "R5", "response data", mem_wr_data, last_resp);
        end
      end
      if (start_rdata[0])
        check(start_rdata == exp_rd, "R2", "busy readback", start_rdata, exp_rd);
    end
    p_cmd = cmd_req;
    p_dat = dat_req;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(start_rdata == 0, "R1", "start readback", start_rdata, 0);
    check(!mem_rd_req && !cmd_req && !dat_req, "R1", "requests idle",
          {mem_rd_req, cmd_req, dat_req}, 0);
    check(!irq_eoc && !irq_err, "R1", "status idle", {irq_eoc, irq_err}, 0);

    // R4 R5 R7, R8 ignore case: command only, misaligned buffer without data phase
    put(32'h100, 0, mk_cfg(17, 0, 0, 1, 0, 0, 0, 0, 1), 32'h1234_5678, 32'h3);
    run_chain(32'h100, "R8");

    // R6: one command streaming into three buffers, mixed units
    put(32'h200, 0, mk_cfg(18, 2, 1, 0, 1, 1, 10, 0, 0), 32'hAAAA_0001, 32'h4000);
    put(32'h200, 1, mk_cfg(0, 300, 0, 0, 1, 1, 10, 1, 0), 32'h0, 32'h5008);
    put(32'h200, 2, mk_cfg(0, 1, 1, 0, 1, 1, 10, 1, 1), 32'h0, 32'h6010);
    run_chain(32'h200, "R8");

    // R4 R6: read chain, command in every descriptor
    put(32'h300, 0, mk_cfg(17, 8, 0, 0, 1, 0, 12, 0, 0), 32'h10, 32'h100);
    put(32'h300, 1, mk_cfg(13, 0, 0, 1, 0, 0, 0, 0, 0), 32'h20, 32'h0);
    put(32'h300, 2, mk_cfg(18, 511, 1, 0, 1, 0, 15, 0, 1), 32'h30, 32'h7F8);
    run_chain(32'h300, "R8");

    // R8: misaligned buffer in the second descriptor aborts the walk
    put(32'h400, 0, mk_cfg(25, 4, 1, 0, 1, 1, 9, 0, 0), 32'h40, 32'h8000);
    put(32'h400, 1, mk_cfg(0, 16, 0, 0, 1, 1, 9, 1, 1), 32'h0, 32'h7004);
    run_chain(32'h400, "R8");

    // R10: stop during the command phase
    clear_q();
    put(32'h500, 0, mk_cfg(12, 0, 0, 0, 0, 0, 0, 0, 1), 32'h50, 32'h0);
    predict(32'h500);
    exp_rd = 32'h501;
    sw_write(32'h501);
    while (!cmd_req) @(negedge clk);
    sw_write(32'h0);
    clear_q();
    check(start_rdata == 0, "R10", "readback after stop", start_rdata, 0);
    check(!cmd_req && !dat_req, "R10", "requests after stop", {cmd_req, dat_req}, 0);
    repeat (10) @(negedge clk);
    check(!irq_eoc && !irq_err, "R10", "no status after stop", {irq_eoc, irq_err}, 0);
    check(!cmd_req && !mem_rd_req, "R10", "quiet after stop", {cmd_req, mem_rd_req}, 0);

    // R9: chain with no end flag runs out of entries
    for (int i = 0; i < MAX_DESC; i++) put(32'h1000, i, 32'h0, 32'h0, 32'h0);
    run_chain(32'h1000, "R9");

    // R7: a fresh start clears the earlier error status
    run_chain(32'h100, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule